// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

This block is a clocked monostable. It replaces RC timing with a cycle count. It produces a single high pulse on `pulse_o`, and its exact complement on `pulse_n_o`, when a valid trigger edge arrives. Two trigger inputs are provided:

- `lead_i` fires on its rising edge, provided `trail_i` is high.
- `trail_i` fires on its falling edge, provided `lead_i` is low.

An unused leading input is therefore tied low, and an unused trailing input is tied high. The functional clear `clr_n` is active low. It overrides everything else: the output is forced idle, and triggers are refused while it is held.

The mode input `retrig_mode` selects one of two behaviours:

- Retriggerable mode: every valid edge restarts the full period, so the pulse ends one period after the last trigger.
- Non-retriggerable mode: the period runs from the first trigger, and later edges are discarded while the pulse is active.

The pulse width is `width_cfg` clock cycles, and a value of zero acts as one.

The controller has three named states:

- `ST_RESET`: the output is held idle. It is entered from any state when the synchronized clear is low, and on `rst_n`. Its only exit goes to `ST_IDLE` on the first cycle the synchronized clear is high. Any edge seen in that cycle is dropped.
- `ST_IDLE`: waiting for a trigger. It goes to `ST_PULSE` on a valid edge, loading the counter with width minus one.
- `ST_PULSE`: the output is high. The counter counts down. In retriggerable mode a valid edge reloads the counter. When the count is zero and no reload happens, the state returns to `ST_IDLE`.

`lead_i`, `trail_i` and `clr_n` all pass through a two-flop synchronizer. Edges are detected on the synchronized values.

Top module: `edge_oneshot`

## Requirements
- R1: An input change that forms a valid trigger changes `pulse_o` at the third rising clock edge after the change, whatever `width_cfg` is.
- R2: A rise of `lead_i` while `trail_i` is high starts a pulse.
- R3: A fall of `trail_i` while `lead_i` is low starts a pulse.
- R4: A rise of `lead_i` while `trail_i` is low starts no pulse. A fall of `trail_i` while `lead_i` is high starts no pulse.
- R5: An untouched pulse is high for exactly `width_cfg` cycles. A `width_cfg` of 0 gives a one-cycle pulse.
- R6: With `retrig_mode` = 1, a valid edge during a pulse restarts timing, so the pulse ends `width_cfg` cycles after the last trigger takes effect.
- R7: With `retrig_mode` = 0, valid edges during a pulse are ignored, and the pulse lasts `width_cfg` cycles from the first trigger.
- R8: `clr_n` low forces `pulse_o` low by the third rising edge after it falls, and no trigger is accepted while it stays low.
- R9: A trigger edge synchronized in the same cycle as the release of `clr_n` is ignored. Later edges work normally.
- R10: After `rst_n` is asserted, `pulse_o` is low.
- R11: `pulse_n_o` is always the inverse of `pulse_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| clr_n | input | 1 | Functional clear, active low, asynchronous to clk |
| lead_i | input | 1 | Leading-edge trigger input |
| trail_i | input | 1 | Trailing-edge trigger input |
| retrig_mode | input | 1 | 1 = retriggerable, 0 = non-retriggerable |
| width_cfg | input | CNT_W | Pulse width in cycles (0 acts as 1) |
| pulse_o | output | 1 | Pulse output, high while active |
| pulse_n_o | output | 1 | Complement of pulse_o |

## Verification
The hardest case to reach is a trigger edge that reaches the controller in exactly the cycle the clear is first seen released. To get there, the bench changes `lead_i` and `clr_n` at the same falling clock edge. Both then travel through identical two-flop synchronizers, so they arrive together. The bench checks that this edge is dropped and that a later edge still produces a full pulse.

A second case needs careful timing: a retrigger that arrives while the pulse is running. The bench gives the leading input a two-cycle low gap, so the second rise survives synchronization while the first pulse is still active. It then checks the total length in both modes.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_IDLE  = 2'd1,
        ST_PULSE = 2'd2
    } os_state_e;
endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
    parameter int          N       = 1,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] meta_q;
    logic [N-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/oneshot_edge.sv
module oneshot_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lead_s,
    input  logic trail_s,
    output logic fire_o
);
    logic lead_q;
    logic trail_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_q  <= 1'b0;
            trail_q <= 1'b1;
        end else begin
            lead_q  <= lead_s;
            trail_q <= trail_s;
        end
    end

    logic lead_rise;
    logic trail_fall;
    assign lead_rise  = lead_s & ~lead_q & trail_s;
    assign trail_fall = ~trail_s & trail_q & ~lead_s;
    assign fire_o     = lead_rise | trail_fall;
endmodule

// File: rtl/oneshot_fsm.sv
module oneshot_fsm
    import oneshot_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_s,
    input  logic             fire,
    input  logic             retrig,
    input  logic [CNT_W-1:0] width,
    output logic             q_o,
    output logic             qn_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    os_state_e        state_q, state_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic [CNT_W-1:0] load_val;
    logic             q_r, qn_r;

    assign load_val = (width == '0) ? '0 : (width - ONE);

    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        if (!clr_s) begin
            state_nx = ST_RESET;
            cnt_nx   = '0;
        end else begin
            unique case (state_q)
                ST_RESET: begin
                    state_nx = ST_IDLE;
                end
                ST_IDLE: begin
                    if (fire) begin
                        state_nx = ST_PULSE;
                        cnt_nx   = load_val;
                    end
                end
                ST_PULSE: begin
                    if (fire && retrig) begin
                        cnt_nx = load_val;
                    end else if (cnt_q == '0) begin
                        state_nx = ST_IDLE;
                    end else begin
                        cnt_nx = cnt_q - ONE;
                    end
                end
                default: begin
                    state_nx = ST_RESET;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r  <= 1'b0;
            qn_r <= 1'b1;
        end else begin
            q_r  <= (state_nx == ST_PULSE);
            qn_r <= (state_nx != ST_PULSE);
        end
    end

    assign q_o  = q_r;
    assign qn_o = qn_r;

    a_r11_complement: assert property (@(posedge clk) disable iff (!rst_n)
        q_r != qn_r);

    a_r8_clear_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> (!q_r && qn_r));

    a_r9_release_drops_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESET) |=> !q_r);

    a_r2_idle_fire_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && fire && clr_s) |=> q_r);

    a_r7_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && !retrig && cnt_q != '0 && clr_s)
        |=> (cnt_q == $past(cnt_q) - ONE));

    a_r5_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && cnt_q == '0 && clr_s && !(fire && retrig))
        |=> !q_r);
endmodule

// File: rtl/edge_oneshot.sv
module edge_oneshot #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             lead_i,
    input  logic             trail_i,
    input  logic             retrig_mode,
    input  logic [CNT_W-1:0] width_cfg,
    output logic             pulse_o,
    output logic             pulse_n_o
);
    localparam int SYNC_N = 3;

    logic [SYNC_N-1:0] raw_in;
    logic [SYNC_N-1:0] syn_in;
    logic              fire;

    assign raw_in = {clr_n, trail_i, lead_i};

    oneshot_sync #(
        .N       (SYNC_N),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    oneshot_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lead_s  (syn_in[0]),
        .trail_s (syn_in[1]),
        .fire_o  (fire)
    );

    oneshot_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_s  (syn_in[2]),
        .fire   (fire),
        .retrig (retrig_mode),
        .width  (width_cfg),
        .q_o    (pulse_o),
        .qn_o   (pulse_n_o)
    );
endmodule

// File: tb/edge_oneshot_tb.sv
module edge_oneshot_tb_top;
    localparam int CNT_W = 16;
    localparam int NVEC  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr_n = 1'b0;
    logic             lead_i = 1'b0;
    logic             trail_i = 1'b1;
    logic             retrig_mode = 1'b1;
    logic [CNT_W-1:0] width_cfg = CNT_W'(4);
    logic             pulse_o, pulse_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    edge_oneshot #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
        .lead_i(lead_i), .trail_i(trail_i),
        .retrig_mode(retrig_mode), .width_cfg(width_cfg),
        .pulse_o(pulse_o), .pulse_n_o(pulse_n_o)
    );

    // fields: lead0 trail0 lead1 trail1 width mode expected_len
    typedef struct packed {
        logic       a0;
        logic       b0;
        logic       a1;
        logic       b1;
        logic [7:0] w;
        logic       m;
        logic [7:0] exp_len;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 1'b1, 1'b1, 8'd4,  1'b1, 8'd4},   // R2
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'd5,  1'b1, 8'd0},   // R4 trail fall, lead high
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd5,  1'b1, 8'd5},   // R3
        '{1'b0, 1'b0, 1'b1, 1'b0, 8'd4,  1'b1, 8'd0},   // R4 lead rise, trail low
        '{1'b0, 1'b1, 1'b1, 1'b1, 8'd0,  1'b1, 8'd1},   // R5 zero width
        '{1'b0, 1'b1, 1'b1, 1'b1, 8'd1,  1'b0, 8'd1},   // R5
        '{1'b0, 1'b1, 1'b1, 1'b1, 8'd9,  1'b0, 8'd9},   // R1
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd12, 1'b0, 8'd12}   // R3
    };

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Called right after an input change at a negedge: checks R1 latency,
    // then counts high samples and checks the complement each cycle.
    task automatic measure(input string req, input int exp_len);
        int len = 0;
        int comp_bad = 0;
        @(negedge clk);
        if (pulse_o) comp_bad++;
        @(negedge clk);
        check({req, "/R1 no early output"}, int'(pulse_o), 0);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (pulse_n_o == pulse_o) comp_bad++;
            if (pulse_o) len++;
            else if (len > 0 || i > 0) break;
        end
        check(req, len, exp_len);
        check("R11", comp_bad, 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_neg(3);
        check("R10 pulse_o", int'(pulse_o), 0);
        check("R11 pulse_n_o", int'(pulse_n_o), 1);
        rst_n = 1'b1;
        wait_neg(2);
        check("R10 after release", int'(pulse_o), 0);
        clr_n = 1'b1;
        wait_neg(6);

        for (int v = 0; v < NVEC; v++) begin
            lead_i      = VECS[v].a0;
            trail_i     = VECS[v].b0;
            retrig_mode = VECS[v].m;
            width_cfg   = CNT_W'(VECS[v].w);
            wait_neg(30);
            lead_i  = VECS[v].a1;
            trail_i = VECS[v].b1;
            measure($sformatf("vec%0d", v), int'(VECS[v].exp_len));
        end

        // R6: retrigger 4 cycles after first edge, width 8 -> 12 high cycles
        lead_i = 1'b0; trail_i = 1'b1; retrig_mode = 1'b1; width_cfg = CNT_W'(8);
        wait_neg(30);
        lead_i = 1'b1;
        fork
            measure("R6 retrigger extends", 12);
            begin wait_neg(2); lead_i = 1'b0; wait_neg(2); lead_i = 1'b1; end
        join
        wait_neg(20);

        // R7: same stimulus, non-retriggerable -> 8 high cycles
        lead_i = 1'b0; retrig_mode = 1'b0;
        wait_neg(30);
        lead_i = 1'b1;
        fork
            measure("R7 retrigger ignored", 8);
            begin wait_neg(2); lead_i = 1'b0; wait_neg(2); lead_i = 1'b1; end
        join
        wait_neg(20);

        // R8: clear during a long pulse
        lead_i = 1'b0; retrig_mode = 1'b1; width_cfg = CNT_W'(40);
        wait_neg(30);
        lead_i = 1'b1;
        wait_neg(8);
        check("R8 pulse running", int'(pulse_o), 1);
        clr_n = 1'b0;
        wait_neg(3);
        check("R8 cleared", int'(pulse_o), 0);
        check("R8 complement", int'(pulse_n_o), 1);
        lead_i = 1'b0;
        wait_neg(3);
        lead_i = 1'b1;
        begin
            int seen = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (pulse_o) seen++;
            end
            check("R8 trigger refused during clear", seen, 0);
        end

        // R9: edge arriving with clear release is dropped
        lead_i = 1'b0; width_cfg = CNT_W'(5);
        wait_neg(5);
        clr_n = 1'b1; lead_i = 1'b1;
        begin
            int seen = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (pulse_o) seen++;
            end
            check("R9 edge at release ignored", seen, 0);
        end
        lead_i = 1'b0;
        wait_neg(4);
        lead_i = 1'b1;
        measure("R9 later edge accepted", 5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule